// File: doc/BRIEF.md
# Interleaved Block Refill Controller

This block serves cache-line refills from a main memory built as four independent banks, each one word wide. A refill request carries a word address. The controller forces that address down to a block boundary and uses one cycle to hand the address to memory. It then starts every bank at once. Bank i works on word i of the block, so the low two word-address bits pick the bank. All banks share one fixed access latency. When it has passed, the four words leave in ascending order over a single word-wide return path, one word per cycle.

The request side is a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from that edge until the refill has finished. A request offered while `req_ready` is low is not taken and has no effect, and the requester may keep `req_valid` asserted until it is taken. The return side has no back-pressure. The cache must accept a word in every cycle in which `rd_valid` is high. `rd_last` marks the fourth word of the block. With the default latency of 15 cycles, a refill takes 1 + 15 + 4 = 20 cycles from acceptance to the last word.

The bank models are behavioural and read-only. The word stored at word address A is `(A * 0x9E3779B1) ^ 0x5A5A0F0F`, truncated to 32 bits and computed modulo 2^32.

Top module: `ilv_refill_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, and `rd_valid` and `rd_last` are 0.
- R2: Once a request is taken, `req_ready` is 0 until the refill has finished. Requests offered while `req_ready` is 0 are ignored: they start nothing and change no returned data.
- R3: Take the cycle that follows the accepting edge as cycle 1. `rd_valid` is then 1 in exactly cycles 17, 18, 19 and 20, and 0 in all other cycles of the refill.
- R4: The beats return the block's words in ascending order. Beat k carries the word at address base+k, where base is the block-aligned request address and word k comes from bank k.
- R5: Bits [1:0] of `req_addr` are ignored. The base is `req_addr` with those bits forced to 0.
- R6: `rd_last` is 1 only with the fourth beat, in cycle 20, which is the total refill latency of 20 cycles.
- R7: The data word for word address A is `(A * 0x9E3779B1) ^ 0x5A5A0F0F`, taken modulo 2^32.
- R8: `req_ready` returns to 1 in the cycle after the last beat. A request held valid across that cycle is taken at the next edge, so refills run back to back with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Refill request offered |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW (16) | Word address of the refill request |
| rd_valid | output | 1 | Returned word valid this cycle |
| rd_data | output | DW (32) | Returned word |
| rd_last | output | 1 | Fourth and final word of the block |

## Verification
The hardest cases to reach are a request that arrives while a refill is in flight and a request that lands in the single cycle in which the controller becomes idle again. The stimulus covers the first by pulsing `req_valid` with an unrelated address in the middle of the bank access. It covers the second by holding `req_valid` high across several refills in a row, so that each new request is taken on the first possible edge. An unaligned address and the top block of the address space show that the low bits are cleared and that the bank words are ordered correctly at the address boundary.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seq_state_t;

  // Content of the behavioural memory at a word address
  function automatic logic [31:0] ilv_pattern(input logic [31:0] waddr);
    return (waddr * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
  endfunction

endpackage

// File: rtl/ilv_bank.sv
module ilv_bank #(
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int LAT = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr,
  output logic          ok,
  output logic [DW-1:0] data
);
  import ilv_pkg::*;

  localparam int CW = $clog2(LAT + 1);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      act_q  <= 1'b0;
      addr_q <= '0;
    end else if (start) begin
      cnt_q  <= CW'(LAT);
      act_q  <= 1'b1;
      addr_q <= addr;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ok   = act_q && (cnt_q == '0);
  assign data = ok ? DW'(ilv_pattern(32'(addr_q))) : '0;

endmodule

// File: rtl/ilv_seq.sv
module ilv_seq #(
  parameter int NBANK = 4,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          all_ok,
  output logic          req_ready,
  output logic          accept,
  output logic          bank_start,
  output logic          beat_valid,
  output logic [BW-1:0] beat_idx,
  output logic          beat_last
);
  import ilv_pkg::*;

  seq_state_t    state_q, state_d;
  logic [BW-1:0] beat_q;

  assign req_ready  = (state_q == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign bank_start = (state_q == ST_ADDR);
  assign beat_valid = (state_q == ST_DATA) && all_ok;
  assign beat_last  = beat_valid && (beat_q == BW'(NBANK - 1));
  assign beat_idx   = beat_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (accept)    state_d = ST_ADDR;
      ST_ADDR:                state_d = ST_DATA;
      ST_DATA: if (beat_last) state_d = ST_IDLE;
      default:                state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (bank_start)      beat_q <= '0;
      else if (beat_valid) beat_q <= beat_q + 1'b1;
    end
  end

endmodule

// File: rtl/ilv_word_mux.sv
module ilv_word_mux #(
  parameter int NBANK = 4,
  parameter int DW    = 32,
  localparam int BW   = $clog2(NBANK)
) (
  input  logic [NBANK-1:0][DW-1:0] words,
  input  logic [BW-1:0]            sel,
  input  logic                     en,
  output logic [DW-1:0]            data
);
  assign data = en ? words[sel] : '0;
endmodule

// File: rtl/ilv_refill_ctrl.sv
module ilv_refill_ctrl #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NBANK = 4,
  parameter int LAT   = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_last
);
  localparam int OFFW = $clog2(NBANK);

  logic                     accept, bank_start, beat_valid, beat_last;
  logic [OFFW-1:0]          beat_idx;
  logic [AW-OFFW-1:0]       blk_q;
  logic [NBANK-1:0]         ok_vec;
  logic [NBANK-1:0][DW-1:0] word_vec;

  // Block number of the accepted request; offset bits are dropped
  always_ff @(posedge clk) begin
    if (!rst_n)      blk_q <= '0;
    else if (accept) blk_q <= req_addr[AW-1:OFFW];
  end

  ilv_seq #(.NBANK(NBANK)) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .all_ok     (&ok_vec),
    .req_ready  (req_ready),
    .accept     (accept),
    .bank_start (bank_start),
    .beat_valid (beat_valid),
    .beat_idx   (beat_idx),
    .beat_last  (beat_last)
  );

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    ilv_bank #(.AW(AW), .DW(DW), .LAT(LAT)) bank_i (
      .clk   (clk),
      .rst_n (rst_n),
      .start (bank_start),
      .addr  ({blk_q, OFFW'(i)}),
      .ok    (ok_vec[i]),
      .data  (word_vec[i])
    );
  end

  ilv_word_mux #(.NBANK(NBANK), .DW(DW)) mux_i (
    .words (word_vec),
    .sel   (beat_idx),
    .en    (beat_valid),
    .data  (rd_data)
  );

  assign rd_valid = beat_valid;
  assign rd_last  = beat_last;

endmodule

// File: rtl/ilv_refill_chk.sv
module ilv_refill_chk #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int NBANK = 4,
  parameter int LAT   = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          rd_valid,
  input logic [DW-1:0] rd_data,
  input logic          rd_last
);
  localparam int TOTAL = 1 + LAT + NBANK;
  localparam int CW    = $clog2(TOTAL + 1);

  // Cycle number within the current refill, 0 when idle
  logic [CW-1:0] cyc_q;
  always_ff @(posedge clk) begin
    if (!rst_n)                        cyc_q <= '0;
    else if (req_valid && req_ready)   cyc_q <= CW'(1);
    else if (cyc_q == CW'(TOTAL))      cyc_q <= '0;
    else if (cyc_q != '0)              cyc_q <= cyc_q + 1'b1;
  end

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_no_ready_in_refill_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q != '0) |-> !req_ready);

  p_valid_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (cyc_q > CW'(LAT + 1)) && (cyc_q <= CW'(TOTAL)));

  p_beats_contiguous_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_last) |=> rd_valid);

  p_last_at_total_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid && (cyc_q == CW'(TOTAL)));

  p_ready_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> req_ready && !rd_valid);

  p_quiet_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> (rd_data == '0) && !rd_last);

endmodule

bind ilv_refill_ctrl ilv_refill_chk #(
  .AW(AW), .DW(DW), .NBANK(NBANK), .LAT(LAT)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .rd_last   (rd_last)
);

// File: tb/ilv_refill_ctrl_tb_top.sv
module ilv_refill_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int NBANK = 4;
  localparam int LAT   = 15;
  localparam int TOTAL = 1 + LAT + NBANK;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rd_valid, rd_last;
  logic [DW-1:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_refill_ctrl #(.AW(AW), .DW(DW), .NBANK(NBANK), .LAT(LAT)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last)
  );

  function automatic logic [31:0] mem_word(input int unsigned a);
    int unsigned p;
    p = a * 32'h9E37_79B1;
    return p ^ 32'h5A5A_0F0F;
  endfunction

  // Behavioural reference: cycle number inside the refill
  int  m_cyc = 0;
  int  m_base = 0;
  bit  m_unal = 0;
  bit  m_acc = 0;
  bit  m_after_last = 0;
  bit  m_first = 1;

  always @(posedge clk) begin
    m_acc = 0;
    m_after_last = 0;
    if (!rst_n) begin
      m_cyc = 0;
    end else if (m_cyc == 0) begin
      if (req_valid) begin
        m_cyc  = 1;
        m_base = int'(req_addr) & ~3;
        m_unal = (req_addr[1:0] != 2'b00);
        m_acc  = 1;
      end
    end else if (m_cyc == TOTAL) begin
      m_cyc = 0;
      m_after_last = 1;
    end else begin
      m_cyc++;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_ready, e_valid, e_last;
      logic [31:0] e_data;
      string t_ready, t_valid;
      e_ready = (m_cyc == 0);
      e_valid = (m_cyc > LAT + 1) && (m_cyc <= TOTAL);
      e_last  = (m_cyc == TOTAL);
      e_data  = e_valid ? mem_word((m_base + m_cyc - LAT - 2) & 32'h0000_FFFF) : 32'h0;
      t_ready = m_first ? "R1" : (m_after_last ? "R8" : "R2");
      t_valid = m_first ? "R1" : "R3";
      chk(req_ready == e_ready, t_ready, "req_ready", 64'(req_ready), 64'(e_ready));
      chk(rd_valid == e_valid, t_valid, "rd_valid", 64'(rd_valid), 64'(e_valid));
      chk(rd_last == e_last, m_first ? "R1" : "R6", "rd_last", 64'(rd_last), 64'(e_last));
      if (e_valid)
        chk(rd_data == e_data, m_unal ? "R5" : "R4 R7", "rd_data",
            64'(rd_data), 64'(e_data));
      m_first = 0;
    end
  end

  task automatic request(input logic [AW-1:0] a, input bit keep);
    @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    do begin
      @(posedge clk);
      #1;
    end while (!m_acc);
    if (!keep) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_addr  = '0;
    end
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (m_cyc != 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic stimulus();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // aligned refill, with an ignored request in the middle of it (R2)
    request(16'h0100, 0);
    repeat (5) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = 16'h0200;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    req_addr  = '0;
    wait_idle();
    // unaligned address, low bits must be cleared (R5)
    request(16'h0123, 0);
    wait_idle();
    // back-to-back refills with valid held high (R8), including top block
    request(16'h0004, 1);
    request(16'h0009, 1);
    request(16'hFFFE, 0);
    wait_idle();
    request(16'h0000, 0);
    wait_idle();
  endtask

  initial begin
    fork
      stimulus();
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule